// File: doc/BRIEF.md
# Serial Two's Complement Converter

This block negates a binary number that arrives one bit per clock, least significant bit first. The result leaves on the output in the same cycle as the matching input bit, so the converted stream has no latency. The rule is the usual serial one. Every bit up to and including the first 1 passes through unchanged. Every bit after that first 1 is inverted.

A pulse on `startIn` marks the first bit of a new word. The bit present on `bitIn` in that cycle is treated as the word's least significant bit. Once started, the machine converts without end, because it has no notion of word length. It keeps going until the next start pulse or a reset.

The state is held in two flip-flops with three used codes:

| State | Code |
|-------|------|
| waiting | 00 |
| passing | 01 |
| flipping | 11 |

The spare code 10 leads back to waiting.

Top module: `serial_twos_comp`

## Requirements
- R1: After a synchronous reset, the machine is in the waiting state (code 00). With `startIn` low, `twosOut` is 0.
- R2: In the waiting state with `startIn` low, `twosOut` is 0 whatever `bitIn` is, and the machine stays waiting.
- R3: In any cycle where `startIn` is 1 and reset is low, `twosOut` equals `bitIn`. That bit is the least significant bit of a new word.
- R4: While no 1 has yet been seen in the current word, `twosOut` equals `bitIn`. This includes the cycle that carries the first 1.
- R5: In every cycle after the first 1 of the current word, `twosOut` equals the inverse of `bitIn`. A word of N bits therefore comes out as its negation modulo 2^N.
- R6: A start pulse while passing or flipping abandons the current word and begins a new one with that cycle's bit.
- R7: Without a new start pulse, the flipping state is kept for any number of cycles. Conversion never ends by itself.
- R8: While `rst` is 1, `twosOut` is 0, and reset takes priority over `startIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Marks the least significant bit of a new word, active high |
| bitIn | input | 1 | Serial input data, least significant bit first |
| twosOut | output | 1 | Serial two's complement of the input, same cycle |

## Verification
The assertions check the following on every cycle:
- the output during a start cycle;
- the silence of the waiting state;
- the inverting relation in the flipping state;
- the stickiness of the flipping state;
- the move to flipping on the first 1;
- the return to waiting after reset;
- the exclusivity of the two datapath strobes.

Some properties only the bench's scenarios can show. These are that whole words of several lengths come out as their arithmetic negation, including the all-zero word and the most negative value. The scenarios also show that a restart in the middle of a word truly discards the earlier word, and that a long run without a start keeps inverting.

// File: rtl/twosc_pkg.sv
`timescale 1ns/1ps
package twosc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_PASS   = 2'b01,
    ST_SPARE  = 2'b10,
    ST_FLIP   = 2'b11
  } convState_e;

  typedef struct packed {
    logic passBit;
    logic flipBit;
  } bitCtrl_t;

endpackage

// File: rtl/twosc_ctrl.sv
`timescale 1ns/1ps
module twosc_ctrl
  import twosc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startIn,
  input  logic       bitIn,
  output bitCtrl_t   strobes,
  output convState_e stateQ
);

  convState_e stateNext;

  always_comb begin
    if (startIn) begin
      stateNext = bitIn ? ST_FLIP : ST_PASS;
    end else begin
      unique case (stateQ)
        ST_IDLE:  stateNext = ST_IDLE;
        ST_PASS:  stateNext = bitIn ? ST_FLIP : ST_PASS;
        ST_FLIP:  stateNext = ST_FLIP;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNext;
  end

  always_comb begin
    strobes.passBit = !rst && (startIn || (stateQ == ST_PASS));
    strobes.flipBit = !rst && !startIn && (stateQ == ST_FLIP);
  end

  // R1: reset always lands in the waiting state
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (stateQ == ST_IDLE));

  // R2: waiting state holds without a start
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == ST_IDLE) && !startIn) |=> (stateQ == ST_IDLE));

  // R4: the first 1 moves the machine to flipping
  p_first_one_r4: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == ST_PASS) && !startIn && bitIn) |=> (stateQ == ST_FLIP));

  // R7: flipping is kept until a start
  p_flip_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == ST_FLIP) && !startIn) |=> (stateQ == ST_FLIP));

endmodule

// File: rtl/twosc_dpath.sv
`timescale 1ns/1ps
module twosc_dpath
  import twosc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bitCtrl_t strobes,
  input  logic     bitIn,
  output logic     twosOut
);

  assign twosOut = (strobes.passBit & bitIn) | (strobes.flipBit & ~bitIn);

  // R3/R5: control never asks for pass and flip together
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.passBit, strobes.flipBit}));

  // R8: no strobe while in reset, so the output is quiet
  a_reset_quiet_r8: assert final (!rst || !twosOut);

endmodule

// File: rtl/serial_twos_comp.sv
`timescale 1ns/1ps
module serial_twos_comp
  import twosc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic startIn,
  input  logic bitIn,
  output logic twosOut
);

  bitCtrl_t   strobes;
  convState_e stateQ;

  twosc_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .startIn (startIn),
    .bitIn   (bitIn),
    .strobes (strobes),
    .stateQ  (stateQ)
  );

  twosc_dpath dpath_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .bitIn   (bitIn),
    .twosOut (twosOut)
  );

  // R3: a start cycle passes its bit straight through
  p_start_pass_r3: assert property (@(posedge clk) disable iff (rst)
    startIn |-> (twosOut == bitIn));

  // R2: waiting without a start keeps the output low
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == ST_IDLE) && !startIn) |-> !twosOut);

  // R5: flipping state inverts the input
  p_flip_out_r5: assert property (@(posedge clk) disable iff (rst)
    ((stateQ == ST_FLIP) && !startIn) |-> (twosOut == !bitIn));

endmodule

// File: tb/serial_twos_comp_tb_top.sv
`timescale 1ns/1ps
module serial_twos_comp_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startIn = 1'b0;
  logic bitIn = 1'b0;
  logic twosOut;

  int checkCount = 0;
  int failCount  = 0;
  int modelState = 0;   // 0 waiting, 1 passing, 2 flipping
  bit finished   = 0;

  always #10 clk = ~clk;   // 50 MHz

  serial_twos_comp dut_i (
    .clk     (clk),
    .rst     (rst),
    .startIn (startIn),
    .bitIn   (bitIn),
    .twosOut (twosOut)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: twosOut=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive after a falling edge, check before the rising edge
  task automatic step(input logic r, input logic s, input logic b,
                      input string tagIn, output logic seen);
    logic  exp;
    string tag;
    rst = r; startIn = s; bitIn = b;
    #5;
    if (r)                    begin exp = 1'b0; tag = "R8"; end
    else if (s)               begin exp = b;    tag = "R3"; end
    else if (modelState == 0) begin exp = 1'b0; tag = "R2"; end
    else if (modelState == 1) begin exp = b;    tag = "R4"; end
    else                      begin exp = ~b;   tag = "R5"; end
    if (tagIn != "") tag = tagIn;
    check(twosOut, exp, tag);
    seen = twosOut;
    if (r)                    modelState = 0;
    else if (s)               modelState = b ? 2 : 1;
    else if (modelState == 1) modelState = b ? 2 : 1;
    @(negedge clk);
  endtask

  // send a whole word and compare with its arithmetic negation
  task automatic sendWord(input logic [31:0] value, input int width, input string tag);
    logic [31:0] got;
    logic [31:0] want;
    logic [31:0] mask;
    logic        seen;
    got  = '0;
    mask = (width == 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 1);
    want = (~value + 32'd1) & mask;
    for (int i = 0; i < width; i++) begin
      step(1'b0, (i == 0), value[i], "", seen);
      got[i] = seen;
    end
    checkCount++;
    if (got !== want) begin
      failCount++;
      $display("FAIL %s: word %h gave %h expected %h", tag, value, got, want);
    end
  endtask

  initial begin
    logic seen;
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, "R8", seen);
    step(1'b1, 1'b1, 1'b1, "R8", seen);     // reset beats start
    step(1'b0, 1'b0, 1'b1, "R1", seen);     // waiting after reset
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, i[0], "R2", seen);

    sendWord(32'h0000_0006, 8,  "R5");
    sendWord(32'h0000_0001, 8,  "R4");
    sendWord(32'h0000_0000, 8,  "R4");
    sendWord(32'h0000_0080, 8,  "R5");
    sendWord(32'h0000_B5A4, 16, "R5");
    sendWord(32'h8000_0000, 32, "R4");

    // R7: long run without start keeps inverting
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, i[1], "R7", seen);

    // R6: restart while flipping, then while passing
    step(1'b0, 1'b1, 1'b0, "R6", seen);
    step(1'b0, 1'b0, 1'b0, "R6", seen);
    step(1'b0, 1'b1, 1'b1, "R6", seen);
    step(1'b0, 1'b0, 1'b0, "R6", seen);
    sendWord(32'h0000_0024, 8, "R6");

    // R8: reset mid-word, then waiting again
    step(1'b1, 1'b0, 1'b1, "R8", seen);
    step(1'b0, 1'b0, 1'b1, "R1", seen);
    step(1'b0, 1'b0, 1'b0, "R2", seen);

    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule